// File: doc/BRIEF.md
# Pin Edge Interrupt Detector

This block watches eight general-purpose input pins and turns selected signal transitions into latched interrupt flags. Each pin has its own interrupt enable and two edge-sensitivity bits, one for rising and one for falling transitions. A pin can therefore respond to either edge, to both, or to none. Each input is first brought into the clock domain through a two-stage synchronizer. The block then compares the synchronized value with the value from the previous cycle to find transitions.

Software reaches three registers over a simple synchronous register bus: the per-pin enable register, the 16-bit edge-control register and the interrupt flag register. The pin flags occupy the upper byte of the flag register. Writing a one to a flag bit clears that bit. If a new event arrives in the same cycle as the clear, the flag stays set. A single interrupt request output is high while any pin flag is set.

Top module: `pin_edge_irq`

## Requirements
- R1: After reset the enable register, the edge-control register and all flags are zero, and irq_o is low.
- R2: The enable register sits at address 0; write data bits [7:0] enable pins 0 to 7, and a read returns them in bits [7:0] with bits [15:8] as zero.
- R3: The edge-control register sits at address 1 and reads back all 16 bits. Bit n enables the rising edge of pin n and bit 8+n enables the falling edge of pin n.
- R4: A rising transition on an enabled pin whose rising bit is set sets flag bit 8+n. The flag becomes visible after the third rising clock edge following the pin change and not after the second.
- R5: A falling transition on an enabled pin whose falling bit is set sets flag bit 8+n. A falling transition on a pin enabled only for rising edges sets nothing.
- R6: A pin with both edge bits set flags on either transition. A pin with neither edge bit set never flags.
- R7: A pin whose enable bit is zero never sets its flag, whatever its edge bits are.
- R8: The flag register sits at address 2, with pin flags in bits [15:8] and bits [7:0] reading zero. Writing a one to bit 8+n clears that flag, and writing a zero leaves it unchanged.
- R9: When a flag set and a write-one clear of the same bit fall on the same clock edge, the flag ends up set.
- R10: irq_o is high exactly when at least one pin flag is set. Clearing one of several set flags keeps it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 8 | Asynchronous pin inputs |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational from address |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A pin change driven before a clock edge passes through two synchronizer flops and one history flop, so its flag and irq_o appear after the third rising edge. The bench reads the flag register after two edges to confirm it is still clear, and again after the third edge to confirm it is set. A register write takes effect on the next rising edge, and read data follows the address without delay. Every read is therefore sampled two nanoseconds after the falling edge at which its address was driven. The set-wins case places a clear write exactly on the third edge after a pin change.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam int unsigned REG_AW = 2;

  typedef enum logic [REG_AW-1:0] {
    REG_EN   = 2'd0,
    REG_EDGE = 2'd1,
    REG_FLAG = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned N      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/edge_detect.sv
module edge_detect #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] level_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;
  assign fall_o = ~level_i & prev_q;
endmodule

// File: rtl/flag_bank.sv
module flag_bank #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~clr_i) | set_i;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/pin_edge_irq.sv
module pin_edge_irq
  import pin_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned FLAG_LSB = 8,
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                reg_we_i,
  input  logic [REG_AW-1:0]   reg_addr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  output logic                irq_o
);
  localparam int unsigned EDGE_W = 2 * NUM_PINS;

  logic [NUM_PINS-1:0] en_q, rise_en_q, fall_en_q;
  logic [NUM_PINS-1:0] pin_sync_s, rise_s, fall_s;
  logic [NUM_PINS-1:0] flag_set, flag_clr, flag_q;

  logic wr_en, wr_edge, wr_flag;
  assign wr_en   = reg_we_i && (reg_addr_i == REG_EN);
  assign wr_edge = reg_we_i && (reg_addr_i == REG_EDGE);
  assign wr_flag = reg_we_i && (reg_addr_i == REG_FLAG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= '0;
      rise_en_q <= '0;
      fall_en_q <= '0;
    end else begin
      if (wr_en) en_q <= reg_wdata_i[NUM_PINS-1:0];
      if (wr_edge) begin
        rise_en_q <= reg_wdata_i[NUM_PINS-1:0];
        fall_en_q <= reg_wdata_i[EDGE_W-1:NUM_PINS];
      end
    end
  end

  pin_sync #(.N(NUM_PINS), .STAGES(SYNC_LEN)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (pin_sync_s)
  );

  edge_detect #(.N(NUM_PINS)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (pin_sync_s),
    .rise_o  (rise_s),
    .fall_o  (fall_s)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_gate
    assign flag_set[p] = en_q[p] & ((rise_s[p] & rise_en_q[p]) | (fall_s[p] & fall_en_q[p]));
    assign flag_clr[p] = wr_flag & reg_wdata_i[FLAG_LSB+p];
  end

  flag_bank #(.N(NUM_PINS)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (flag_set),
    .clr_i  (flag_clr),
    .flag_o (flag_q)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      REG_EN:   reg_rdata_o[NUM_PINS-1:0] = en_q;
      REG_EDGE: reg_rdata_o[EDGE_W-1:0]   = {fall_en_q, rise_en_q};
      REG_FLAG: reg_rdata_o[FLAG_LSB +: NUM_PINS] = flag_q;
      default:  reg_rdata_o = '0;
    endcase
  end

  assign irq_o = |flag_q;
endmodule

// File: rtl/pin_edge_irq_chk.sv
module pin_edge_irq_chk
  import pin_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned FLAG_LSB = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                reg_we_i,
  input logic [REG_AW-1:0]   reg_addr_i,
  input logic [DATA_W-1:0]   reg_wdata_i,
  input logic                irq_o,
  input logic [NUM_PINS-1:0] en,
  input logic [NUM_PINS-1:0] set,
  input logic [NUM_PINS-1:0] flag
);
  logic flag_wr;
  assign flag_wr = reg_we_i && (reg_addr_i == REG_FLAG);

  assert_en_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == REG_EN) |=> (en == $past(reg_wdata_i[NUM_PINS-1:0])));

  assert_irq_holds_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !flag_wr) |=> irq_o);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assert_set_needs_enable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set[p] |-> en[p]);

    assert_no_spurious_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!flag[p] && !set[p]) |=> !flag[p]);

    assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set[p] |=> flag[p]);

    assert_write_one_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_wr && reg_wdata_i[FLAG_LSB+p] && !set[p]) |=> !flag[p]);
  end
endmodule

bind pin_edge_irq pin_edge_irq_chk #(
  .NUM_PINS (NUM_PINS),
  .DATA_W   (DATA_W),
  .FLAG_LSB (FLAG_LSB)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .irq_o       (irq_o),
  .en          (en_q),
  .set         (flag_set),
  .flag        (flag_q)
);

// File: tb/pin_edge_irq_tb_top.sv
`timescale 1ns/1ps
module pin_edge_irq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pins = '0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  always #5 clk = ~clk;

  pin_edge_irq dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pin_i       (pins),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq)
  );

  typedef struct {
    string       tag;
    logic [15:0] data;
    logic        irq;
  } exp_t;

  exp_t sb_q[$];
  logic sb_v = 1'b0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  // monitor: sample 2 ns after the falling edge
  always begin
    exp_t e;
    @(negedge clk);
    #2;
    if (sb_v && sb_q.size() > 0) begin
      e = sb_q.pop_front();
      n_chk++;
      if (rdata !== e.data || irq !== e.irq) begin
        n_fail++;
        $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                 e.tag, rdata, irq, e.data, e.irq);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [15:0] exp_d,
                    input logic exp_irq, input string tag);
    exp_t e;
    e.tag = tag; e.data = exp_d; e.irq = exp_irq;
    sb_q.push_back(e);
    addr = a; sb_v = 1'b1;
    @(negedge clk);
    sb_v = 1'b0;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      report();
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    rd(2'd0, 16'h0000, 1'b0, "R1 enable reset");
    rd(2'd1, 16'h0000, 1'b0, "R1 edge reset");
    rd(2'd2, 16'h0000, 1'b0, "R1 flag reset");

    // R2 enable register, upper bits read zero
    wr(2'd0, 16'hFF2F);
    rd(2'd0, 16'h002F, 1'b0, "R2 enable readback");
    // R3 edge control: rise pins 0,2,3,4; fall pins 1,2,3,4
    wr(2'd1, 16'h1E1D);
    rd(2'd1, 16'h1E1D, 1'b0, "R3 edge readback");

    // R4 rising on pin 0, latency of three edges
    pins = 8'h01;
    tick(2);
    rd(2'd2, 16'h0000, 1'b0, "R4 not before third edge");
    rd(2'd2, 16'h0100, 1'b1, "R4 rise flag pin0");
    // R8 write of zero to the flag is ignored, low byte reads zero
    wr(2'd2, 16'h00FE);
    rd(2'd2, 16'h0100, 1'b1, "R8 write zero keeps flag");
    wr(2'd2, 16'h0100);
    rd(2'd2, 16'h0000, 1'b0, "R8 write one clears");

    // R5 falling on a rise-only pin is ignored
    pins = 8'h00;
    tick(2);
    rd(2'd2, 16'h0000, 1'b0, "R5 fall on rise-only pin0");
    rd(2'd2, 16'h0000, 1'b0, "R5 fall on rise-only pin0 late");

    // R5 pin 1 fall-only
    pins = 8'h02;
    tick(2);
    rd(2'd2, 16'h0000, 1'b0, "R5 rise on fall-only pin1");
    rd(2'd2, 16'h0000, 1'b0, "R5 rise on fall-only pin1 late");
    pins = 8'h00;
    tick(2);
    rd(2'd2, 16'h0000, 1'b0, "R5 fall pin1 early");
    rd(2'd2, 16'h0200, 1'b1, "R5 fall flag pin1");
    wr(2'd2, 16'h0200);

    // R7 pin 4 has edges set but is disabled
    pins = 8'h10;
    tick(4);
    rd(2'd2, 16'h0000, 1'b0, "R7 disabled pin4 rise");
    pins = 8'h00;
    tick(4);
    rd(2'd2, 16'h0000, 1'b0, "R7 disabled pin4 fall");

    // R6 pin 2 both edges
    pins = 8'h04;
    tick(3);
    rd(2'd2, 16'h0400, 1'b1, "R6 both-edge pin2 rise");
    wr(2'd2, 16'h0400);
    pins = 8'h00;
    tick(3);
    rd(2'd2, 16'h0400, 1'b1, "R6 both-edge pin2 fall");
    wr(2'd2, 16'h0400);
    // R6 pin 5 enabled but no edge bits
    pins = 8'h20;
    tick(4);
    pins = 8'h00;
    tick(4);
    rd(2'd2, 16'h0000, 1'b0, "R6 no-edge pin5");

    // R9 set wins over a clear on the same edge
    pins = 8'h08;
    tick(3);
    rd(2'd2, 16'h0800, 1'b1, "R9 pin3 rise flag");
    pins = 8'h00;
    tick(2);
    wr(2'd2, 16'h0800);
    rd(2'd2, 16'h0800, 1'b1, "R9 set wins over clear");
    wr(2'd2, 16'h0800);
    rd(2'd2, 16'h0000, 1'b0, "R9 later clear");

    // R10 irq is OR of several flags
    pins = 8'h05;
    tick(2);
    rd(2'd2, 16'h0000, 1'b0, "R10 two pins early");
    rd(2'd2, 16'h0500, 1'b1, "R10 two flags");
    wr(2'd2, 16'h0100);
    rd(2'd2, 16'h0400, 1'b1, "R10 one flag left keeps irq");
    wr(2'd2, 16'h0400);
    rd(2'd2, 16'h0000, 1'b0, "R10 all clear drops irq");

    tick(2);
    done = 1'b1;
    report();
  end
endmodule